// File: doc/BRIEF.md
# Eight-Stage Pipeline Operand Bypass Selector

This block decides where each source operand of an in-order eight-stage pipeline takes its value from. The stages, oldest instruction last, run fetch, predict/register-read, decode (ID), execute (EX), memory-read (MR), memory-write (MW), write-back (WB) and a final forward-only stage (FW). Because the register file is read two stages ahead of execute, a value read there may already be stale by the time the instruction decodes or executes. This selector compares every source register number in ID and EX with the destination numbers and write enables of the older instructions that can bypass to that stage, and emits a mux select code for each operand.

ID operands can bypass from MR, WB and FW. EX operands can bypass from MR and WB only. When several older instructions write the same register, the youngest wins. When the winning producer has no result yet, such as a load still in its cache read, the selector raises a stall request for the consuming stage. The block is purely combinational. The datapath muxes that use the select codes sit outside it.

Top module: `fwd_select`

## Requirements
- R1: Each ID operand select is 2 bits: 0 = register-file value, 1 = MR result, 2 = WB result, 3 = FW result. Operand k uses bits [2k+1:2k] of `id_sel`.
- R2: Each EX operand select is 2 bits: 0 = value carried from ID, 1 = MR result, 2 = WB result. Operand k uses bits [2k+1:2k] of `ex_sel`. Code 3 never appears, and a match with FW alone leaves an EX select at 0.
- R3: A producer matches only when its write enable is 1 and its destination equals the source number. A deasserted write enable makes it invisible even if its number and readiness match.
- R4: For ID operands, when several producers match, MR wins over WB and WB wins over FW.
- R5: For EX operands, when both producers match, MR wins over WB.
- R6: Source register 0 never matches any producer. Its select is 0 and it never causes a stall.
- R7: `stall_id` is 1 when the producer chosen for some ID operand has its ready flag at 0. A ready lower-priority match does not cancel the stall.
- R8: `stall_ex` is 1 when the producer chosen for some EX operand has its ready flag at 0.
- R9: Operands are resolved independently. A stall in one stage does not raise the other stage's stall.
- R10: The FW result is always available, so an FW selection never causes a stall.
- R11: All outputs follow the inputs combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_src | input | NUM_OPS*REG_W | Source register numbers of the instruction in ID |
| ex_src | input | NUM_OPS*REG_W | Source register numbers of the instruction in EX |
| mr_dst | input | REG_W | Destination register of the instruction in MR |
| mr_we | input | 1 | MR instruction writes a register |
| mr_rdy | input | 1 | MR result is available this cycle |
| wb_dst | input | REG_W | Destination register of the instruction in WB |
| wb_we | input | 1 | WB instruction writes a register |
| wb_rdy | input | 1 | WB result is available this cycle |
| fw_dst | input | REG_W | Destination register of the instruction in FW |
| fw_we | input | 1 | FW instruction writes a register |
| id_sel | output | NUM_OPS*2 | Per-operand bypass select for ID |
| ex_sel | output | NUM_OPS*2 | Per-operand bypass select for EX |
| stall_id | output | 1 | ID must hold because a needed value is missing |
| stall_ex | output | 1 | EX must hold because a needed value is missing |

## Verification
Every output is due in the same cycle its inputs are applied, because no register lies between the ports. The bench changes inputs just after a rising clock edge and samples the select codes and stall flags at the following falling edge. This leaves half a period for the logic to settle and keeps the sample clear of the edge at which inputs change. Every vector, whether from the table or from the directed sweeps, is checked before the next one is applied.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Select code values shared by ID and EX operand muxes
  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_MR   = 2'd1,
    SRC_WB   = 2'd2,
    SRC_FW   = 2'd3
  } src_sel_e;

  localparam int unsigned ID_NPROD = 3;  // MR, WB, FW
  localparam int unsigned EX_NPROD = 2;  // MR, WB
  localparam int unsigned SEL_W    = 2;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NPROD = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic [REG_W-1:0]       src,
  input  logic [NPROD*REG_W-1:0] dst,
  input  logic [NPROD-1:0]       we,
  input  logic [NPROD-1:0]       rdy,
  output logic [SEL_W-1:0]       sel,
  output logic                   pend
);
  logic [NPROD-1:0] hit;
  logic             src_live;

  assign src_live = (src != '0);

  generate
    for (genvar g = 0; g < NPROD; g++) begin : g_cmp
      assign hit[g] = src_live && we[g] && (dst[g*REG_W +: REG_W] == src);
    end
  endgenerate

  // Index 0 is the youngest producer; scanning downward leaves it the winner
  always_comb begin
    sel  = '0;
    pend = 1'b0;
    for (int k = NPROD - 1; k >= 0; k--) begin
      if (hit[k]) begin
        sel  = SEL_W'(k + 1);
        pend = !rdy[k];
      end
    end
  end

  always_comb begin
    if (!src_live) begin
      assert_zero_reg_idle_R6: assert (sel == '0 && !pend)
        else $error("register 0 produced a bypass select");
    end
    if (pend) begin
      assert_pend_has_sel_R7: assert (sel != '0)
        else $error("pending without a selected producer");
    end
    for (int k = 0; k < NPROD; k++) begin
      if (sel == SEL_W'(k + 1)) begin
        assert_sel_is_enabled_R3: assert (we[k] && dst[k*REG_W +: REG_W] == src)
          else $error("select points at a non-matching producer");
      end
    end
  end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_OPS = 2
) (
  input  logic [NUM_OPS*REG_W-1:0] id_src,
  input  logic [NUM_OPS*REG_W-1:0] ex_src,
  input  logic [REG_W-1:0]         mr_dst,
  input  logic                     mr_we,
  input  logic                     mr_rdy,
  input  logic [REG_W-1:0]         wb_dst,
  input  logic                     wb_we,
  input  logic                     wb_rdy,
  input  logic [REG_W-1:0]         fw_dst,
  input  logic                     fw_we,
  output logic [NUM_OPS*SEL_W-1:0] id_sel,
  output logic [NUM_OPS*SEL_W-1:0] ex_sel,
  output logic                     stall_id,
  output logic                     stall_ex
);
  // Producer vectors, youngest at index 0
  logic [ID_NPROD*REG_W-1:0] id_dst_v;
  logic [ID_NPROD-1:0]       id_we_v;
  logic [ID_NPROD-1:0]       id_rdy_v;
  logic [EX_NPROD*REG_W-1:0] ex_dst_v;
  logic [EX_NPROD-1:0]       ex_we_v;
  logic [EX_NPROD-1:0]       ex_rdy_v;
  logic [NUM_OPS-1:0]        id_pend;
  logic [NUM_OPS-1:0]        ex_pend;

  assign id_dst_v = {fw_dst, wb_dst, mr_dst};
  assign id_we_v  = {fw_we, wb_we, mr_we};
  assign id_rdy_v = {1'b1, wb_rdy, mr_rdy};   // FW result always present
  assign ex_dst_v = {wb_dst, mr_dst};
  assign ex_we_v  = {wb_we, mr_we};
  assign ex_rdy_v = {wb_rdy, mr_rdy};

  generate
    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
      fwd_pick #(.REG_W(REG_W), .NPROD(ID_NPROD), .SEL_W(SEL_W)) u_id (
        .src  (id_src[op*REG_W +: REG_W]),
        .dst  (id_dst_v),
        .we   (id_we_v),
        .rdy  (id_rdy_v),
        .sel  (id_sel[op*SEL_W +: SEL_W]),
        .pend (id_pend[op])
      );
      fwd_pick #(.REG_W(REG_W), .NPROD(EX_NPROD), .SEL_W(SEL_W)) u_ex (
        .src  (ex_src[op*REG_W +: REG_W]),
        .dst  (ex_dst_v),
        .we   (ex_we_v),
        .rdy  (ex_rdy_v),
        .sel  (ex_sel[op*SEL_W +: SEL_W]),
        .pend (ex_pend[op])
      );

      always_comb begin
        assert_ex_no_fw_code_R2: assert (ex_sel[op*SEL_W +: SEL_W] != SRC_FW)
          else $error("EX operand selected the FW path");
        if (id_sel[op*SEL_W +: SEL_W] == SRC_FW) begin
          assert_fw_never_pends_R10: assert (!id_pend[op])
            else $error("FW selection raised a pending flag");
        end
      end
    end
  endgenerate

  assign stall_id = |id_pend;
  assign stall_ex = |ex_pend;

  always_comb begin
    if (stall_id) begin
      assert_stall_id_has_src_R7: assert (id_sel != '0)
        else $error("ID stall with no bypass selected");
    end
    if (stall_ex) begin
      assert_stall_ex_has_src_R8: assert (ex_sel != '0)
        else $error("EX stall with no bypass selected");
    end
  end
endmodule

// File: tb/tb_fwd_select.sv
module tb_fwd_select;
  localparam int REG_W = 5;
  localparam int NOPS  = 2;

  logic clk;
  logic [NOPS*REG_W-1:0] id_src, ex_src;
  logic [REG_W-1:0] mr_dst, wb_dst, fw_dst;
  logic mr_we, mr_rdy, wb_we, wb_rdy, fw_we;
  logic [3:0] id_sel, ex_sel;
  logic stall_id, stall_ex;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 4 ns period

  fwd_select #(.REG_W(REG_W), .NUM_OPS(NOPS)) dut (
    .id_src(id_src), .ex_src(ex_src),
    .mr_dst(mr_dst), .mr_we(mr_we), .mr_rdy(mr_rdy),
    .wb_dst(wb_dst), .wb_we(wb_we), .wb_rdy(wb_rdy),
    .fw_dst(fw_dst), .fw_we(fw_we),
    .id_sel(id_sel), .ex_sel(ex_sel),
    .stall_id(stall_id), .stall_ex(stall_ex)
  );

  typedef struct packed {
    logic [4:0] id0, id1, ex0, ex1, mrd, wbd, fwd;
    logic       mwe, mrdy, wwe, wrdy, fwe;
    logic [3:0] e_id, e_ex;
    logic       e_sid, e_sex;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // no write enables: everything from base (R3)
    '{5'd1, 5'd2, 5'd3, 5'd4, 5'd1, 5'd2, 5'd3, 1'b0,1'b1,1'b0,1'b1,1'b0, 4'b0000, 4'b0000, 1'b0,1'b0},
    // MR and WB single matches (R1, R2)
    '{5'd5, 5'd6, 5'd5, 5'd6, 5'd5, 5'd6, 5'd7, 1'b1,1'b1,1'b1,1'b1,1'b1, 4'b1001, 4'b1001, 1'b0,1'b0},
    // FW only: ID picks 3, EX stays 0 (R2, R10)
    '{5'd7, 5'd7, 5'd7, 5'd0, 5'd5, 5'd6, 5'd7, 1'b1,1'b1,1'b1,1'b1,1'b1, 4'b1111, 4'b0000, 1'b0,1'b0},
    // all three match: MR wins (R4, R5)
    '{5'd9, 5'd9, 5'd9, 5'd9, 5'd9, 5'd9, 5'd9, 1'b1,1'b1,1'b1,1'b1,1'b1, 4'b0101, 4'b0101, 1'b0,1'b0},
    // WB beats FW, mixed operands (R4, R5)
    '{5'd9, 5'd5, 5'd9, 5'd3, 5'd5, 5'd9, 5'd9, 1'b1,1'b1,1'b1,1'b1,1'b1, 4'b0110, 4'b0010, 1'b0,1'b0},
    // register 0 everywhere, MR not ready (R6)
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1,1'b0,1'b1,1'b1,1'b1, 4'b0000, 4'b0000, 1'b0,1'b0},
    // MR not ready, ready WB behind it (R7, R8)
    '{5'd9, 5'd2, 5'd9, 5'd2, 5'd9, 5'd9, 5'd3, 1'b1,1'b0,1'b1,1'b1,1'b0, 4'b0001, 4'b0001, 1'b1,1'b1},
    // ID stalls alone (R9)
    '{5'd4, 5'd9, 5'd4, 5'd8, 5'd9, 5'd6, 5'd7, 1'b1,1'b0,1'b0,1'b1,1'b0, 4'b0100, 4'b0000, 1'b1,1'b0},
    // WB not ready, FW ready behind it (R7, R8)
    '{5'd6, 5'd1, 5'd1, 5'd6, 5'd3, 5'd6, 5'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 4'b0010, 4'b1000, 1'b1,1'b1},
    // MR disabled but matching and not ready (R3)
    '{5'd9, 5'd1, 5'd9, 5'd1, 5'd9, 5'd9, 5'd3, 1'b0,1'b0,1'b1,1'b1,1'b0, 4'b0010, 4'b0010, 1'b0,1'b0}
  };

  task automatic check(input string req, input logic [3:0] eid, input logic [3:0] eex,
                       input logic esid, input logic esex);
    n_chk++;
    if (id_sel !== eid || ex_sel !== eex || stall_id !== esid || stall_ex !== esex) begin
      n_fail++;
      $display("FAIL %s: id_sel=%b ex_sel=%b stall_id=%b stall_ex=%b expected %b %b %b %b",
               req, id_sel, ex_sel, stall_id, stall_ex, eid, eex, esid, esex);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    id_src = {v.id1, v.id0};
    ex_src = {v.ex1, v.ex0};
    mr_dst = v.mrd; wb_dst = v.wbd; fw_dst = v.fwd;
    mr_we = v.mwe; mr_rdy = v.mrdy; wb_we = v.wwe; wb_rdy = v.wrdy; fw_we = v.fwe;
    @(negedge clk);
  endtask

  initial begin
    id_src = '0; ex_src = '0;
    mr_dst = '0; wb_dst = '0; fw_dst = '0;
    mr_we = 0; mr_rdy = 0; wb_we = 0; wb_rdy = 0; fw_we = 0;
    @(negedge clk);
    // idle inputs: all selects base, no stall (R11 same-cycle response)
    check("R11 idle", 4'b0000, 4'b0000, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R1/R2 table vector %0d", i), VECS[i].e_id, VECS[i].e_ex,
            VECS[i].e_sid, VECS[i].e_sex);
    end

    // FW sweep over every live register: ID gets 3, EX stays 0 (R10, R2)
    for (int r = 1; r < 32; r++) begin
      apply('{5'(r), 5'(r), 5'(r), 5'(r), 5'd0, 5'd0, 5'(r),
              1'b0,1'b0,1'b0,1'b0,1'b1, 4'b0, 4'b0, 1'b0,1'b0});
      check("R10 fw sweep", 4'b1111, 4'b0000, 1'b0, 1'b0);
    end

    // register 0 with every producer naming it and nothing ready (R6)
    apply('{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,
            1'b1,1'b0,1'b1,1'b0,1'b1, 4'b0, 4'b0, 1'b0,1'b0});
    check("R6 zero reg", 4'b0000, 4'b0000, 1'b0, 1'b0);

    // EX stalls alone on WB not ready, ID unaffected (R9, R8)
    apply('{5'd2, 5'd3, 5'd12, 5'd1, 5'd4, 5'd12, 5'd5,
            1'b1,1'b1,1'b1,1'b0,1'b1, 4'b0, 4'b0, 1'b0,1'b0});
    check("R9 ex-only stall", 4'b0000, 4'b0010, 1'b0, 1'b1);

    // mid-cycle input change reflected before the next edge (R11)
    @(posedge clk);
    #1 id_src = {5'd0, 5'd4};
    @(negedge clk);
    check("R11 same-cycle", 4'b0001, 4'b0010, 1'b0, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule